// File: doc/BRIEF.md
# Fetch-Execute Sequencer with Interrupt and Trap Entry

This block is the control sequencer of a small stored-program machine. It keeps a program counter and an instruction register. It walks each instruction through a fetch, a load and an execute phase, and then reaches an instruction boundary. At that boundary it decides whether to fetch the next instruction, stop for good, or enter the interrupt routine. The datapath is not part of this block. The execute phase is a one-cycle stub that handles only the control-flow opcodes: jump, trap, return from interrupt, and interrupt enable and disable.

The block owns a single synchronous memory port: address, write data, write enable, and read data that arrives one cycle after the address. Each memory access gets its own state.

Interrupt entry happens only at an instruction boundary, and only while interrupts are enabled. On entry the block clears the enable, stores the return address in word 0, and fetches the handler address from word 1.

A trap instruction enters supervisor mode and loads the program counter from a vector table that starts at word 1000. No interrupt can come between the mode change and the vector load. A trap number outside the table sets a sticky error flag and the block moves on to the next instruction.

Top module: `fx_sequencer`

## Requirements
- R1: While reset is held, and right after it is released: pc_o = 16, int_en_o = 0, super_o = 0, halted_o = 0 and trap_err_o = 0. The first read address driven after reset is 16.
- R2: An instruction word has its opcode in bits [15:12] and its argument in bits [11:0]. Opcode 0 is no-op, 4 sets the interrupt enable, 5 clears it, and any opcode not given a meaning here behaves as a no-op. Each of these advances the PC by 1. Opcode 1 loads the PC from argument bits [10:0]. retire_o pulses for exactly one cycle for each completed instruction.
- R3: A high level on halt_i is latched and stays latched. The instruction in flight completes, after which no further instruction is fetched, halted_o goes to 1, the PC stays frozen and the memory is never written.
- R4: irq_i is looked at only at the instruction boundary. A request that is gone before the boundary is never taken. A request is ignored while the interrupt enable is 0.
- R5: Interrupt entry clears the interrupt enable, writes the PC of the next instruction to word 0, and then loads the PC from word 1. This save is the only memory write the block ever makes.
- R6: Trap (opcode 2) with a number n from 0 to 7 in the argument sets super_o and loads the PC from word 1000+n.
- R7: Trap dispatch is atomic. A request pending during a trap is taken only after the vector has been loaded, so the saved return address is the trap target.
- R8: A trap number of 8 or more sets trap_err_o, which then stays set until reset. The PC advances by 1 and the mode does not change.
- R9: Return (opcode 3) loads the PC from word 0, sets the interrupt enable and clears super_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 11 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |
| irq_i | input | 1 | Interrupt request, level |
| halt_i | input | 1 | Halt request |
| pc_o | output | 11 | Program counter |
| int_en_o | output | 1 | Interrupt enable |
| super_o | output | 1 | Supervisor mode |
| halted_o | output | 1 | Sequencer has stopped |
| retire_o | output | 1 | Instruction boundary pulse |
| trap_err_o | output | 1 | Sticky out-of-range trap flag |

## Verification
The assertions check several rules on every cycle:
- a write goes only to word 0, carries the current PC and happens with the interrupt enable already clear;
- a write starts only right after a boundary pulse;
- the halted state freezes the PC;
- the trap error never clears;
- clearing supervisor mode always comes together with the interrupt enable being set;
- no save follows a mode change straight away.

The scenarios in the bench show the rest. They cover the values loaded from the vector words, the return addresses seen in memory after entry from a plain instruction and from a trap, and a request pulse that ends before the boundary and is not taken. They also cover a disabled request that is ignored, out-of-range and edge trap numbers, and the instruction that finishes after halt is raised.

// File: rtl/fx_pkg.sv
package fx_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_NOP  = 4'h0;
   localparam logic [OPC_W-1:0] OP_JMP  = 4'h1;
   localparam logic [OPC_W-1:0] OP_TRAP = 4'h2;
   localparam logic [OPC_W-1:0] OP_RETI = 4'h3;
   localparam logic [OPC_W-1:0] OP_EI   = 4'h4;
   localparam logic [OPC_W-1:0] OP_DI   = 4'h5;

   typedef enum logic [3:0] {
      ST_FETCH,
      ST_LOAD,
      ST_EXEC,
      ST_BOUND,
      ST_SAVE,
      ST_IVEC_RD,
      ST_IVEC_LD,
      ST_TVEC_RD,
      ST_TVEC_LD,
      ST_RVEC_RD,
      ST_RVEC_LD,
      ST_STOP
   } fx_state_e;

   typedef struct packed {
      logic is_jmp;
      logic is_trap;
      logic is_reti;
      logic is_ei;
      logic is_di;
      logic trap_ok;
   } fx_dec_t;

endpackage

// File: rtl/fx_decode.sv
module fx_decode
   import fx_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter int TRAP_COUNT = 8,
   localparam int ARG_W     = DATA_W - OPC_W,
   localparam int TIDX_W    = (TRAP_COUNT > 1) ? $clog2(TRAP_COUNT) : 1
)(
   input  logic [DATA_W-1:0] ir_i,
   output fx_dec_t           dec_o,
   output logic [ADDR_W-1:0] jump_tgt_o,
   output logic [TIDX_W-1:0] trap_idx_o
);

   logic [OPC_W-1:0] opc;
   logic [ARG_W-1:0] arg;
   logic             in_range;

   assign opc = ir_i[DATA_W-1 -: OPC_W];
   assign arg = ir_i[ARG_W-1:0];

   // Range check variant: skipped when the table spans every argument value
   generate
      if (TRAP_COUNT >= (1 << ARG_W)) begin : g_full_table
         assign in_range = 1'b1;
      end else begin : g_partial_table
         assign in_range = (arg < ARG_W'(TRAP_COUNT));
      end
   endgenerate

   always_comb begin
      dec_o         = '0;
      dec_o.is_jmp  = (opc == OP_JMP);
      dec_o.is_trap = (opc == OP_TRAP);
      dec_o.is_reti = (opc == OP_RETI);
      dec_o.is_ei   = (opc == OP_EI);
      dec_o.is_di   = (opc == OP_DI);
      dec_o.trap_ok = in_range;
   end

   assign jump_tgt_o = arg[ADDR_W-1:0];
   assign trap_idx_o = arg[TIDX_W-1:0];

endmodule

// File: rtl/fx_memport.sv
module fx_memport
   import fx_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter int SAVE_ADDR  = 0,
   parameter int ISR_PTR    = 1,
   parameter int TRAP_BASE  = 1000,
   parameter int TRAP_COUNT = 8,
   localparam int TIDX_W    = (TRAP_COUNT > 1) ? $clog2(TRAP_COUNT) : 1
)(
   input  fx_state_e         state_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [TIDX_W-1:0] trap_idx_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              we_o
);

   localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
   localparam logic [ADDR_W-1:0] ISR_A  = ADDR_W'(ISR_PTR);
   localparam logic [ADDR_W-1:0] TBASE  = ADDR_W'(TRAP_BASE);

   always_comb begin
      addr_o  = pc_i;
      we_o    = 1'b0;
      wdata_o = DATA_W'(pc_i);
      unique case (state_i)
         ST_SAVE: begin
            addr_o = SAVE_A;
            we_o   = 1'b1;
         end
         ST_IVEC_RD: addr_o = ISR_A;
         ST_TVEC_RD: addr_o = TBASE + ADDR_W'(trap_idx_i);
         ST_RVEC_RD: addr_o = SAVE_A;
         default:    addr_o = pc_i;
      endcase
   end

endmodule

// File: rtl/fx_fsm.sv
module fx_fsm
   import fx_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter int START_ADDR = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic              irq_i,
   input  logic              halt_i,
   input  fx_dec_t           dec_i,
   input  logic [ADDR_W-1:0] jump_tgt_i,
   output fx_state_e         state_o,
   output logic [DATA_W-1:0] ir_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic              ie_o,
   output logic              sup_o,
   output logic              err_o,
   output logic              halted_o,
   output logic              retire_o
);

   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_ADDR);

   fx_state_e         state_q, state_d;
   logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
   logic [DATA_W-1:0] ir_q;
   logic              ie_q, ie_d;
   logic              sup_q, sup_d;
   logic              err_q, err_d;
   logic              halt_q;

   assign pc_inc = pc_q + ADDR_W'(1);

   always_comb begin
      state_d = state_q;
      pc_d    = pc_q;
      ie_d    = ie_q;
      sup_d   = sup_q;
      err_d   = err_q;
      unique case (state_q)
         ST_FETCH: state_d = ST_LOAD;
         ST_LOAD:  state_d = ST_EXEC;
         ST_EXEC: begin
            state_d = ST_BOUND;
            pc_d    = pc_inc;
            if (dec_i.is_jmp) begin
               pc_d = jump_tgt_i;
            end else if (dec_i.is_trap) begin
               if (dec_i.trap_ok) begin
                  sup_d   = 1'b1;
                  pc_d    = pc_q;
                  state_d = ST_TVEC_RD;
               end else begin
                  err_d = 1'b1;
               end
            end else if (dec_i.is_reti) begin
               pc_d    = pc_q;
               state_d = ST_RVEC_RD;
            end else if (dec_i.is_ei) begin
               ie_d = 1'b1;
            end else if (dec_i.is_di) begin
               ie_d = 1'b0;
            end
         end
         ST_TVEC_RD: state_d = ST_TVEC_LD;
         ST_TVEC_LD: begin
            pc_d    = rdata_i[ADDR_W-1:0];
            state_d = ST_BOUND;
         end
         ST_RVEC_RD: state_d = ST_RVEC_LD;
         ST_RVEC_LD: begin
            pc_d    = rdata_i[ADDR_W-1:0];
            ie_d    = 1'b1;
            sup_d   = 1'b0;
            state_d = ST_BOUND;
         end
         ST_BOUND: begin
            if (halt_q) begin
               state_d = ST_STOP;
            end else if (irq_i && ie_q) begin
               ie_d    = 1'b0;
               state_d = ST_SAVE;
            end else begin
               state_d = ST_FETCH;
            end
         end
         ST_SAVE:    state_d = ST_IVEC_RD;
         ST_IVEC_RD: state_d = ST_IVEC_LD;
         ST_IVEC_LD: begin
            pc_d    = rdata_i[ADDR_W-1:0];
            state_d = ST_FETCH;
         end
         ST_STOP: state_d = ST_STOP;
         default: state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= PC_RST;
         ir_q    <= '0;
         ie_q    <= 1'b0;
         sup_q   <= 1'b0;
         err_q   <= 1'b0;
         halt_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         ie_q    <= ie_d;
         sup_q   <= sup_d;
         err_q   <= err_d;
         halt_q  <= halt_q | halt_i;
         if (state_q == ST_LOAD) begin
            ir_q <= rdata_i;
         end
      end
   end

   assign state_o  = state_q;
   assign ir_o     = ir_q;
   assign pc_o     = pc_q;
   assign ie_o     = ie_q;
   assign sup_o    = sup_q;
   assign err_o    = err_q;
   assign halted_o = (state_q == ST_STOP);
   assign retire_o = (state_q == ST_BOUND);

endmodule

// File: rtl/fx_sequencer.sv
module fx_sequencer
   import fx_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 11,
   parameter int START_ADDR = 16,
   parameter int SAVE_ADDR  = 0,
   parameter int ISR_PTR    = 1,
   parameter int TRAP_BASE  = 1000,
   parameter int TRAP_COUNT = 8,
   localparam int TIDX_W    = (TRAP_COUNT > 1) ? $clog2(TRAP_COUNT) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_we_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              irq_i,
   input  logic              halt_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic              int_en_o,
   output logic              super_o,
   output logic              halted_o,
   output logic              retire_o,
   output logic              trap_err_o
);

   initial begin
      if (DATA_W - OPC_W < ADDR_W)
         $error("fx_sequencer: argument field narrower than the address");
      if (TRAP_BASE + TRAP_COUNT > (1 << ADDR_W))
         $error("fx_sequencer: trap table exceeds the address space");
      if (START_ADDR >= (1 << ADDR_W) || ISR_PTR >= (1 << ADDR_W))
         $error("fx_sequencer: fixed address out of range");
      if (TRAP_COUNT < 1)
         $error("fx_sequencer: trap table must hold at least one entry");
   end

   fx_state_e         state;
   logic [DATA_W-1:0] ir;
   fx_dec_t           dec;
   logic [ADDR_W-1:0] jump_tgt;
   logic [TIDX_W-1:0] trap_idx;

   fx_decode #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .TRAP_COUNT (TRAP_COUNT)
   ) u_decode (
      .ir_i       (ir),
      .dec_o      (dec),
      .jump_tgt_o (jump_tgt),
      .trap_idx_o (trap_idx)
   );

   fx_fsm #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .rdata_i    (mem_rdata_i),
      .irq_i      (irq_i),
      .halt_i     (halt_i),
      .dec_i      (dec),
      .jump_tgt_i (jump_tgt),
      .state_o    (state),
      .ir_o       (ir),
      .pc_o       (pc_o),
      .ie_o       (int_en_o),
      .sup_o      (super_o),
      .err_o      (trap_err_o),
      .halted_o   (halted_o),
      .retire_o   (retire_o)
   );

   fx_memport #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .SAVE_ADDR  (SAVE_ADDR),
      .ISR_PTR    (ISR_PTR),
      .TRAP_BASE  (TRAP_BASE),
      .TRAP_COUNT (TRAP_COUNT)
   ) u_memport (
      .state_i    (state),
      .pc_i       (pc_o),
      .trap_idx_i (trap_idx),
      .addr_o     (mem_addr_o),
      .wdata_o    (mem_wdata_o),
      .we_o       (mem_we_o)
   );

endmodule

// File: rtl/fx_sequencer_chk.sv
module fx_sequencer_chk #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 11,
   parameter int SAVE_ADDR = 0
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_we_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic              int_en_o,
   input logic              super_o,
   input logic              halted_o,
   input logic              retire_o,
   input logic              trap_err_o
);

   p_save_word0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_addr_o == ADDR_W'(SAVE_ADDR)));

   p_save_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_wdata_o == DATA_W'(pc_o)) && !int_en_o);

   p_entry_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_o) |-> $past(retire_o));

   p_halt_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o && $stable(pc_o) && !retire_o && !mem_we_o);

   p_retire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retire_o |=> !retire_o);

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap_err_o |=> trap_err_o);

   p_return_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(super_o) |-> int_en_o);

   p_trap_atomic_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(super_o) |=> !mem_we_o);

endmodule

bind fx_sequencer fx_sequencer_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .SAVE_ADDR (SAVE_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_addr_o  (mem_addr_o),
   .mem_wdata_o (mem_wdata_o),
   .mem_we_o    (mem_we_o),
   .pc_o        (pc_o),
   .int_en_o    (int_en_o),
   .super_o     (super_o),
   .halted_o    (halted_o),
   .retire_o    (retire_o),
   .trap_err_o  (trap_err_o)
);

// File: tb/tb_fx_sequencer.sv
module tb_fx_sequencer;

   localparam int DW = 16;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata = '0;
   logic          irq = 1'b0;
   logic          halt = 1'b0;
   logic [AW-1:0] pc;
   logic          int_en, sup, halted, retire, trap_err;

   logic [DW-1:0] mem [0:(1<<AW)-1];

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   fx_sequencer dut (
      .clk(clk), .rst_n(rst_n),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
      .mem_rdata_i(mem_rdata), .irq_i(irq), .halt_i(halt),
      .pc_o(pc), .int_en_o(int_en), .super_o(sup), .halted_o(halted),
      .retire_o(retire), .trap_err_o(trap_err)
   );

   // irq: 0 low, 1 held high, 2 short pulse gone before the boundary
   typedef struct packed {
      int irq; int pc; int sup; int ie; int err; int save;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{0,  17, 0, 1, 0, -1},   // EI at 16            R2
      '{1,  18, 0, 1, 0, -1},   // NOP at 17, irq      R4
      '{0,  65, 0, 0, 0, 18},   // handler NOP at 64   R5
      '{0,  18, 0, 1, 0, -1},   // RETI at 65          R9
      '{1,  80, 1, 1, 0, -1},   // TRAP 3 at 18, irq   R6 R7
      '{0,  65, 1, 0, 0, 80},   // handler NOP         R7
      '{0,  80, 0, 1, 0, -1},   // RETI                R9
      '{2,  81, 0, 1, 0, -1},   // NOP at 80, pulse    R4
      '{0,  82, 0, 0, 0, -1},   // DI at 81            R2
      '{1,  83, 0, 0, 0, -1},   // NOP at 82, disabled R4
      '{0,  84, 0, 0, 1, 80},   // TRAP 9 at 83        R8
      '{0, 100, 0, 0, 1, -1},   // JMP 100 at 84       R2
      '{0, 120, 1, 0, 1, -1},   // TRAP 0 at 100       R6
      '{0, 130, 1, 0, 1, -1},   // TRAP 7 at 120       R6
      '{0, 131, 1, 0, 1, -1}    // opcode F at 130     R2
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic wait_retire(output bit ok);
      ok = 1'b0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (retire) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      bit ok;
      int nret;
      for (int a = 0; a < (1<<AW); a++) mem[a] = '0;
      mem[1]    = 16'd64;
      mem[1000] = 16'd120;
      mem[1003] = 16'd80;
      mem[1007] = 16'd130;
      mem[16]  = 16'h4000;
      mem[17]  = 16'h0000;
      mem[18]  = 16'h2003;
      mem[64]  = 16'h0000;
      mem[65]  = 16'h3000;
      mem[80]  = 16'h0000;
      mem[81]  = 16'h5000;
      mem[82]  = 16'h0000;
      mem[83]  = 16'h2009;
      mem[84]  = 16'h1064;
      mem[100] = 16'h2000;
      mem[120] = 16'h2007;
      mem[130] = 16'hF000;
      mem[131] = 16'h0000;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "pc", int'(pc), 16);
      chk("R1", "int_en", int'(int_en), 0);
      chk("R1", "super", int'(sup), 0);
      chk("R1", "halted", int'(halted), 0);
      chk("R1", "trap_err", int'(trap_err), 0);
      chk("R1", "we", int'(mem_we), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "first fetch addr", int'(mem_addr), 16);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].irq == 2) begin
            irq = 1'b1;
            @(posedge clk); @(posedge clk); #1 irq = 1'b0;
         end else begin
            irq = (TBL[i].irq == 1);
         end
         wait_retire(ok);
         chk("R2", $sformatf("retire seen v%0d", i), int'(ok), 1);
         if (!ok) break;
         chk("R2", $sformatf("pc v%0d", i), int'(pc), TBL[i].pc);
         chk("R6", $sformatf("super v%0d", i), int'(sup), TBL[i].sup);
         chk("R4", $sformatf("int_en v%0d", i), int'(int_en), TBL[i].ie);
         chk("R8", $sformatf("trap_err v%0d", i), int'(trap_err), TBL[i].err);
         if (TBL[i].save >= 0)
            chk("R5", $sformatf("saved pc v%0d", i), int'(mem[0]), TBL[i].save);
         @(posedge clk); #1;
      end
      irq = 1'b0;

      // R3: halt during instruction at 131, it completes then the block stops
      halt = 1'b1;
      nret = 0;
      for (int c = 0; c < 30; c++) begin
         @(negedge clk);
         if (retire) nret++;
      end
      chk("R3", "retires after halt", nret, 1);
      chk("R3", "halted", int'(halted), 1);
      chk("R3", "pc frozen", int'(pc), 132);
      halt = 1'b0;
      nret = 0;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         if (retire || mem_we) nret++;
      end
      chk("R3", "activity after stop", nret, 0);
      chk("R3", "pc still", int'(pc), 132);
      chk("R5", "word 0 untouched", int'(mem[0]), 80);

      done = 1;
      summary();
      $finish;
   end

endmodule